// File: doc/BRIEF.md
# Bus Clock Stop Gate

This block drives a group of single-ended bus clock outputs and can park them low on demand. The stop request comes from two places: an active-low external pin, and a run bit held in a small control register. The bus clocks run only while both are high, so either one going low stops them. The pin is asynchronous and passes through a multi-flop synchronizer before it is used.

Some outputs can be built as free-run capable. Each of those has a free-run bit in a second register. When that bit is set, the output keeps toggling during a stop. All other outputs rest at logic low while stopped.

The bus clock is generated from the system clock as a square wave with a programmable half period. The gate enable and the free-run selection are updated only during the low half of that wave. Stopping and restarting therefore never produce a shortened or stretched high pulse. Restart completes within two bus clock periods plus the synchronizer and output register delay.

Reading the control register does not return the bit that was written. It returns the combined run state, so software sees 0 whenever the pin or the written bit is low. A status output reports when every stoppable output has settled low.

Top module: `bus_clk_stop`

## Requirements
- R1: After reset every bus clock output is low, the run bit is 1, the free-run bits are 0 and `stopped_o` is 0. The outputs then toggle with a period of 2*HALF_PERIOD system clocks, which is 10 rising edges in any 40-cycle window at HALF_PERIOD=2.
- R2: When `stop_n` is held low, every output that is not free-running stops, rests low and shows no rising edge.
- R3: Writing 0 to bit 0 of register 0 (`wr_addr`=0) stops the same outputs even while `stop_n` is high. Because the two sources are combined by AND, returning `stop_n` high does not restart the outputs while the run bit is 0.
- R4: Register 1 (`wr_addr`=1) holds one free-run bit per output. Only bit positions set in FREE_CAPABLE can be set; the others ignore writes and read back 0. A set and capable bit keeps its output toggling through a stop.
- R5: `rd_data` is registered and valid one cycle after `rd_addr`. With `rd_addr`=0, bit 0 reads the synchronized pin AND the run bit, and the upper bits read 0. With `rd_addr`=1, it reads the free-run register.
- R6: When both stop sources are high again, output 0 shows its first rising edge within 4*HALF_PERIOD+3 system clock cycles of `stop_n` rising.
- R7: Every high pulse on every output lasts exactly HALF_PERIOD system clocks, including across stops, restarts, short pin pulses and free-run changes. The gate enable changes only while the bus clock phase is low.
- R8: `stopped_o` rises only once the gate is off and all stoppable outputs are low. It is 0 no later than the first rising edge of a stoppable output after a restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stop_n | input | 1 | Asynchronous active-low stop request pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write register select: 0 run control, 1 free-run mask |
| wr_data | input | NUM_OUT | Write data; bit 0 is the run bit for register 0 |
| rd_addr | input | 1 | Read register select |
| rd_data | output | NUM_OUT | Registered read data |
| bus_clk_o | output | NUM_OUT | Gated bus clock outputs |
| stopped_o | output | 1 | All stoppable outputs parked low |

## Verification
The bench stops the outputs through the pin alone, through the register bit alone, and through both at once. Comparing the three shows whether the two sources are really combined by AND and not by OR or with one of them ignored. It drives all four combinations of pin and run bit and reads register 0 each time, which separates the combined readback from a raw echo of the written bit. It writes all ones to the free-run register so that capable and incapable bits can be told apart by toggle counts. It sweeps the restart point and a range of short pin pulses across every phase of the bus clock, and measures pulse widths and restart latency. This exposes gating that is updated in the wrong half of the clock period.

// File: rtl/bus_clk_stop_pkg.sv
package bus_clk_stop_pkg;
  typedef enum logic {
    REG_CTRL = 1'b0,
    REG_FREE = 1'b1
  } reg_sel_e;

  localparam int RUN_BIT = 0;
endpackage

// File: rtl/bus_clk_stop_sync.sv
module bus_clk_stop_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  generate
    if (STAGES < 2) begin : g_single
      logic s;
      always_ff @(posedge clk) begin
        if (rst) s <= RST_VAL;
        else     s <= d;
      end
      assign q = s;
    end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= {STAGES{RST_VAL}};
        else     sh <= {sh[STAGES-2:0], d};
      end
      assign q = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/bus_clk_stop_phase.sv
module bus_clk_stop_phase #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst,
  output logic phase_o
);
  localparam int            CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign phase_o = ph_q;
endmodule

// File: rtl/bus_clk_stop_regs.sv
module bus_clk_stop_regs
  import bus_clk_stop_pkg::*;
#(
  parameter int                 NUM_OUT      = 8,
  parameter logic [NUM_OUT-1:0] FREE_CAPABLE = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [NUM_OUT-1:0] wr_data,
  input  logic               rd_addr,
  input  logic               pin_sync,
  output logic               run_eff_o,
  output logic [NUM_OUT-1:0] free_o,
  output logic [NUM_OUT-1:0] rd_data_o
);
  logic               run_q;
  logic [NUM_OUT-1:0] free_q;
  logic [NUM_OUT-1:0] rd_q;
  logic [NUM_OUT-1:0] ctrl_view;

  assign run_eff_o = pin_sync & run_q;
  assign ctrl_view = {{(NUM_OUT-1){1'b0}}, run_eff_o};

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b1;
      free_q <= '0;
      rd_q   <= '0;
    end else begin
      if (wr_en) begin
        if (wr_addr == REG_CTRL) run_q  <= wr_data[RUN_BIT];
        else                     free_q <= wr_data & FREE_CAPABLE;
      end
      rd_q <= (rd_addr == REG_CTRL) ? ctrl_view : free_q;
    end
  end

  assign free_o    = free_q;
  assign rd_data_o = rd_q;
endmodule

// File: rtl/bus_clk_stop_gate.sv
module bus_clk_stop_gate #(
  parameter int NUM_OUT = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               phase,
  input  logic               run_req,
  input  logic [NUM_OUT-1:0] free_req,
  output logic [NUM_OUT-1:0] clk_o,
  output logic               stopped_o,
  output logic               gate_en_o,
  output logic [NUM_OUT-1:0] free_g_o
);
  logic               gate_en_q;
  logic [NUM_OUT-1:0] free_g_q;
  logic               stopped_q;

  // Enables move only on edges that sample the low half of the bus clock.
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_en_q <= 1'b1;
      free_g_q  <= '0;
    end else if (!phase) begin
      gate_en_q <= run_req;
      free_g_q  <= free_req;
    end
  end

  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= phase & (gate_en_q | free_g_q[g]);
      end
      assign clk_o[g] = q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) stopped_q <= 1'b0;
    else     stopped_q <= ~gate_en_q & ~|(clk_o & ~free_g_q);
  end

  assign stopped_o = stopped_q;
  assign gate_en_o = gate_en_q;
  assign free_g_o  = free_g_q;
endmodule

// File: rtl/bus_clk_stop.sv
module bus_clk_stop
  import bus_clk_stop_pkg::*;
#(
  parameter int                 NUM_OUT      = 8,
  parameter int                 HALF_PERIOD  = 2,
  parameter int                 SYNC_STAGES  = 2,
  parameter logic [NUM_OUT-1:0] FREE_CAPABLE = {2'b11, {(NUM_OUT-2){1'b0}}}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stop_n,
  input  logic               wr_en,
  input  logic               wr_addr,
  input  logic [NUM_OUT-1:0] wr_data,
  input  logic               rd_addr,
  output logic [NUM_OUT-1:0] rd_data,
  output logic [NUM_OUT-1:0] bus_clk_o,
  output logic               stopped_o
);
  logic               pin_sync_w;
  logic               run_eff_w;
  logic               phase_w;
  logic               gate_en_w;
  logic [NUM_OUT-1:0] free_w;
  logic [NUM_OUT-1:0] free_g_w;

  bus_clk_stop_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (stop_n),
    .q   (pin_sync_w)
  );

  bus_clk_stop_phase #(.HALF(HALF_PERIOD)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .phase_o (phase_w)
  );

  bus_clk_stop_regs #(.NUM_OUT(NUM_OUT), .FREE_CAPABLE(FREE_CAPABLE)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .pin_sync  (pin_sync_w),
    .run_eff_o (run_eff_w),
    .free_o    (free_w),
    .rd_data_o (rd_data)
  );

  bus_clk_stop_gate #(.NUM_OUT(NUM_OUT)) u_gate (
    .clk       (clk),
    .rst       (rst),
    .phase     (phase_w),
    .run_req   (run_eff_w),
    .free_req  (free_w),
    .clk_o     (bus_clk_o),
    .stopped_o (stopped_o),
    .gate_en_o (gate_en_w),
    .free_g_o  (free_g_w)
  );
endmodule

// File: rtl/bus_clk_stop_chk.sv
module bus_clk_stop_chk
  import bus_clk_stop_pkg::*;
#(
  parameter int                 NUM_OUT      = 8,
  parameter logic [NUM_OUT-1:0] FREE_CAPABLE = '0
) (
  input logic               clk,
  input logic               rst,
  input logic               phase,
  input logic               gate_en,
  input logic               run_eff,
  input logic [NUM_OUT-1:0] free_g,
  input logic [NUM_OUT-1:0] bus_clk_o,
  input logic               stopped_o,
  input logic               rd_addr,
  input logic [NUM_OUT-1:0] rd_data
);
  p_quiet_when_stopped_r8: assert property (@(posedge clk) disable iff (rst)
    stopped_o |-> ((bus_clk_o & ~free_g) == '0));

  p_status_clears_r8: assert property (@(posedge clk) disable iff (rst)
    gate_en |=> !stopped_o);

  p_gate_hold_high_r7: assert property (@(posedge clk) disable iff (rst)
    phase |=> $stable(gate_en) && $stable(free_g));

  p_gate_off_r2: assert property (@(posedge clk) disable iff (rst)
    (!run_eff && !phase) |=> !gate_en);

  p_ctrl_readback_r5: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == REG_CTRL) |=> (rd_data[0] == $past(run_eff)) &&
                              (rd_data[NUM_OUT-1:1] == '0));

  p_free_mask_r4: assert property (@(posedge clk) disable iff (rst)
    (rd_addr == REG_FREE) |=> ((rd_data & ~FREE_CAPABLE) == '0));
endmodule

bind bus_clk_stop bus_clk_stop_chk #(
  .NUM_OUT      (NUM_OUT),
  .FREE_CAPABLE (FREE_CAPABLE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .phase     (phase_w),
  .gate_en   (gate_en_w),
  .run_eff   (run_eff_w),
  .free_g    (free_g_w),
  .bus_clk_o (bus_clk_o),
  .stopped_o (stopped_o),
  .rd_addr   (rd_addr),
  .rd_data   (rd_data)
);

// File: tb/bus_clk_stop_bench.sv
module bus_clk_stop_bench;
  localparam int             N    = 4;
  localparam int             HALF = 2;
  localparam logic [N-1:0]   CAP  = 4'b1100;
  localparam int             PER  = 2 * HALF;
  localparam int             WIN  = 40;
  localparam int             LAT  = 4 * HALF + 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         stop_n = 1'b1;
  logic         wr_en = 1'b0;
  logic         wr_addr = 1'b0;
  logic [N-1:0] wr_data = '0;
  logic         rd_addr = 1'b0;
  logic [N-1:0] rd_data;
  logic [N-1:0] bus_clk;
  logic         stopped;

  always #2.5ns clk = ~clk;

  bus_clk_stop #(
    .NUM_OUT(N), .HALF_PERIOD(HALF), .SYNC_STAGES(2), .FREE_CAPABLE(CAP)
  ) u_bus_clk_stop (
    .clk(clk), .rst(rst), .stop_n(stop_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .bus_clk_o(bus_clk), .stopped_o(stopped)
  );

  int           tests = 0;
  int           fails = 0;
  int           rises [N];
  int           hilen [N];
  int           pulse_bad = 0;
  int           cyc = 0;
  logic [N-1:0] prev = '0;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // Monitor: rising edges and high-pulse widths, sampled on falling edges.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      for (int i = 0; i < N; i++) begin
        if (bus_clk[i] && !prev[i]) rises[i]++;
        if (bus_clk[i]) hilen[i]++;
        else begin
          if (prev[i] && hilen[i] != HALF) pulse_bad++;
          hilen[i] = 0;
        end
      end
      prev = bus_clk;
    end
    if (cyc > 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc_wait(input int n);
    repeat (n) @(negedge clk);
    #1ns;
  endtask

  task automatic wr(input logic a, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [N-1:0] v);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    #1ns;
    v = rd_data;
  endtask

  task automatic window(input string req, input logic [N-1:0] running);
    for (int i = 0; i < N; i++) rises[i] = 0;
    cyc_wait(WIN);
    for (int i = 0; i < N; i++) begin
      int exp = running[i] ? WIN / PER : 0;
      chk(rises[i] == exp, req, rises[i], exp);
    end
  endtask

  task automatic restart_latency();
    int n = 0;
    while (n < LAT + 10 && !bus_clk[0]) begin
      @(negedge clk);
      #1ns;
      n++;
    end
    chk(n >= 1 && n <= LAT, "R6 restart latency", n, LAT);
    chk(stopped == 1'b0, "R8 status cleared at restart", int'(stopped), 0);
  endtask

  initial begin
    logic [N-1:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    cyc_wait(1);
    // R1 reset state
    chk(bus_clk == '0, "R1 outputs low after reset", int'(bus_clk), 0);
    chk(stopped == 1'b0, "R1 status low after reset", int'(stopped), 0);
    rd(1'b0, v);
    chk(v == 4'b0001, "R1 run bit reset", int'(v), 1);
    rd(1'b1, v);
    chk(v == 4'b0000, "R1 free bits reset", int'(v), 0);
    window("R1 free toggling rate", 4'b1111);

    // R2 pin stop
    @(negedge clk); stop_n = 1'b0;
    cyc_wait(20);
    rd(1'b0, v);
    chk(v == 4'b0000, "R5 readback with pin low", int'(v), 0);
    window("R2 pin stop", 4'b0000);
    chk(bus_clk == '0, "R2 outputs rest low", int'(bus_clk), 0);
    chk(stopped == 1'b1, "R8 status set when stopped", int'(stopped), 1);
    @(negedge clk); stop_n = 1'b1;
    restart_latency();
    window("R1 running after restart", 4'b1111);

    // R3 register stop and AND with pin
    wr(1'b0, 4'b0000);
    cyc_wait(20);
    window("R3 register stop", 4'b0000);
    @(negedge clk); stop_n = 1'b0;
    cyc_wait(10);
    @(negedge clk); stop_n = 1'b1;
    cyc_wait(10);
    window("R3 pin release does not override register", 4'b0000);
    rd(1'b0, v);
    chk(v == 4'b0000, "R3 readback stays 0", int'(v), 0);
    wr(1'b0, 4'b0001);
    cyc_wait(LAT);
    window("R3 run bit restores", 4'b1111);

    // R5 readback sweep over pin x run bit
    for (int p = 0; p < 2; p++) begin
      for (int r = 0; r < 2; r++) begin
        @(negedge clk); stop_n = p[0];
        wr(1'b0, {3'b000, r[0]});
        cyc_wait(4);
        rd(1'b0, v);
        chk(v == {3'b000, p[0] & r[0]}, "R5 combined readback", int'(v), p & r);
      end
    end
    @(negedge clk); stop_n = 1'b1;
    wr(1'b0, 4'b0001);
    cyc_wait(LAT);

    // R4 free-run mask
    wr(1'b1, 4'b1111);
    rd(1'b1, v);
    chk(v == CAP, "R4 incapable bits read 0", int'(v), int'(CAP));
    @(negedge clk); stop_n = 1'b0;
    cyc_wait(20);
    window("R4 free outputs run through stop", CAP);
    chk(stopped == 1'b1, "R8 status with free outputs running", int'(stopped), 1);
    wr(1'b1, 4'b0000);
    cyc_wait(20);
    window("R4 cleared free bits stop", 4'b0000);
    wr(1'b1, 4'b0100);
    cyc_wait(20);
    window("R4 single free bit", 4'b0100);
    wr(1'b1, 4'b0000);
    @(negedge clk); stop_n = 1'b1;
    restart_latency();

    // R6 latency sweep over release phase
    for (int k = 0; k < PER; k++) begin
      @(negedge clk); stop_n = 1'b0;
      cyc_wait(20 + k);
      @(negedge clk); stop_n = 1'b1;
      restart_latency();
    end

    // R7 short pin pulses at every phase
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk); stop_n = 1'b0;
      repeat (k) @(negedge clk);
      stop_n = 1'b1;
      repeat (k + 3) @(negedge clk);
    end
    cyc_wait(20);
    window("R7 running after pulse sweep", 4'b1111);
    chk(pulse_bad == 0, "R7 every high pulse full width", pulse_bad, 0);

    summary();
    $finish;
  end
endmodule